// File: doc/BRIEF.md
# Serial Byte Receiver with Break Detection and Line Wake-Up

This block takes an asynchronous serial line and turns it into bytes. Each frame is one low start bit, eight data bits sent least significant first, and one high stop bit (8N1). Bit timing comes from an oversampling tick input that pulses once per sixteenth of a bit period. Each received byte goes into a single holding register with a valid flag. The valid flag stays set until the consumer pulses a read strobe. A stop bit sampled low marks the byte with a framing error. A byte of zero with a framing error is also reported as a line break, which is the header that starts a master frame on single-wire automotive buses.

An optional wake mode parks the receiver. Software arms it through a strobe. While it is armed, the receiver assembles no frames and only watches the line for one falling edge followed by one rising edge. When the rising edge arrives, the receiver pulses a wake event for one cycle, clears the armed bit itself, and returns to normal reception. The next byte then arrives and is flagged as usual.

The state machine has seven states. IDLE waits for a low line. START re-checks the low level at mid start bit. DATA samples the eight bits. STOP samples the stop bit and delivers the frame. FLUSH waits for the line to go high after a framing error. WFALL and WRISE wait for the two wake edges. The transitions are:
- IDLE→WFALL when armed.
- IDLE→START on a low line.
- START→IDLE on a glitch.
- START→DATA on a confirmed start.
- DATA→STOP after the eighth bit.
- STOP→IDLE on a good stop bit.
- STOP→FLUSH on a bad stop bit.
- FLUSH→IDLE on a high line.
- WFALL→WRISE on a low line.
- WRISE→IDLE on a high line.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, rx_valid, frame_err, brk_det, overrun, wake_en and wake_evt are 0 and rx_data is 0x00.
- R2: A frame is received as follows: a low start bit, then 8 data bits least significant bit first, then a stop bit, each bit lasting 16 os_tick pulses. The byte appears on rx_data with rx_valid set to 1, and rx_valid stays 1 until it is read.
- R3: The start bit is confirmed on the 8th tick after the falling edge. A low pulse that has ended by then is discarded, and the receiver returns to IDLE without delivering a byte.
- R4: A stop bit sampled as 0 sets frame_err to 1, and the byte is still delivered with rx_valid set to 1.
- R5: brk_det is 1 exactly when the held byte has frame_err set to 1 and a value of 0x00.
- R6: After a framing error, no new start bit is searched for until the line has returned high. A long low line therefore yields exactly one byte.
- R7: A one-cycle rd_ack pulse clears rx_valid, frame_err, brk_det and overrun to 0.
- R8: If a frame completes while rx_valid is 1 and rd_ack is 0, overrun is set to 1 and the held byte is left unchanged. The new byte is discarded.
- R9: If a frame completes in the same cycle as rd_ack, the new byte is loaded, rx_valid stays 1 and overrun stays 0.
- R10: A wake_set pulse sets wake_en to 1. While wake_en is 1, no frame is assembled and rx_valid does not rise.
- R11: While armed, a falling edge followed by a rising edge on rxd gives a single-cycle wake_evt pulse. wake_en clears to 0 in that same cycle.
- R12: After a wake event, the next frame is received normally and sets rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| wake_set | input | 1 | Strobe that arms wake mode |
| rd_ack | input | 1 | Read strobe for the held byte |
| rx_data | output | 8 | Held byte |
| rx_valid | output | 1 | Held byte not yet read (receive interrupt) |
| frame_err | output | 1 | Held byte had a low stop bit |
| brk_det | output | 1 | Held byte is a break |
| overrun | output | 1 | A byte was lost while the held byte was unread |
| wake_en | output | 1 | Wake mode armed |
| wake_evt | output | 1 | One-cycle pulse on wake |

## Verification
Frame completion and a consumer read can land on the same clock edge. The holding register then has to choose between reporting an overrun and accepting the new byte. The bench measures the cycle latency from the start-bit edge to rx_valid on an earlier frame, with the tick phase aligned. It then starts a second frame at the same tick phase and places rd_ack exactly on the completion edge. It judges the result by rx_valid still being 1, rx_data holding the new byte and overrun staying 0.

// File: rtl/urx_pkg.sv
package urx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_FLUSH,
        ST_WFALL,
        ST_WRISE
    } urx_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_hold.sv
module urx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          fe_in,
    input  logic          rd_ack,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          ferr,
    output logic          brk,
    output logic          ovr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
            ferr  <= 1'b0;
            brk   <= 1'b0;
            ovr   <= 1'b0;
        end else if (load) begin
            if (valid && !rd_ack) begin
                ovr <= 1'b1;
            end else begin
                data  <= din;
                valid <= 1'b1;
                ferr  <= fe_in;
                brk   <= fe_in && (din == '0);
                ovr   <= 1'b0;
            end
        end else if (rd_ack) begin
            valid <= 1'b0;
            ferr  <= 1'b0;
            brk   <= 1'b0;
            ovr   <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8,
    parameter int SYNC_FF   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 wake_set,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 frame_err,
    output logic                 brk_det,
    output logic                 overrun,
    output logic                 wake_en,
    output logic                 wake_evt
);
    import urx_pkg::*;

    localparam int CW  = $clog2(OSR);
    localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] TOPB = BW'(DATA_BITS - 1);

    urx_state_e           state, nxt;
    logic                 rx_s;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 frame_done;
    logic                 bit_end;
    logic                 wake_hit;

    urx_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    assign bit_end    = os_tick && (cnt == LAST);
    assign frame_done = (state == ST_STOP) && bit_end;
    assign wake_hit   = (state == ST_WRISE) && rx_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (wake_en) nxt = ST_WFALL;
                      else if (!rx_s) nxt = ST_START;
            ST_START: if (os_tick && cnt == MID) nxt = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (bit_end && bitn == TOPB) nxt = ST_STOP;
            ST_STOP:  if (bit_end) nxt = rx_s ? ST_IDLE : ST_FLUSH;
            ST_FLUSH: if (rx_s) nxt = ST_IDLE;
            ST_WFALL: if (!rx_s) nxt = ST_WRISE;
            ST_WRISE: if (rx_s) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs of the machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            wake_en  <= 1'b0;
            wake_evt <= 1'b0;
        end else begin
            if (state != nxt) cnt <= '0;
            else if (os_tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;

            if (state == ST_START) bitn <= '0;
            else if (state == ST_DATA && bit_end) bitn <= bitn + 1'b1;

            if (state == ST_DATA && bit_end)
                shreg <= {rx_s, shreg[DATA_BITS-1:1]};

            wake_evt <= wake_hit;
            if (wake_hit)      wake_en <= 1'b0;
            else if (wake_set) wake_en <= 1'b1;
        end
    end

    urx_hold #(.DW(DATA_BITS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_done),
        .din    (shreg),
        .fe_in  (!rx_s),
        .rd_ack (rd_ack),
        .data   (rx_data),
        .valid  (rx_valid),
        .ferr   (frame_err),
        .brk    (brk_det),
        .ovr    (overrun)
    );
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_ack,
    input logic                 frame_done,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 frame_err,
    input logic                 brk_det,
    input logic                 overrun,
    input logic                 wake_en,
    input logic                 wake_evt
);
    // R5
    p_brk_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |-> (frame_err && rx_data == '0));

    // R2
    p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_ack) |=> rx_valid);

    // R7
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !frame_done) |=> (!rx_valid && !overrun));

    // R8
    p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && frame_done && !rd_ack) |=> (overrun && $stable(rx_data)));

    // R11
    p_wake_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> !wake_en);

    p_wake_fell_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_en) |-> wake_evt);

    p_wake_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);
endmodule

bind uart_rx_wake uart_rx_wake_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ack     (rd_ack),
    .frame_done (frame_done),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .frame_err  (frame_err),
    .brk_det    (brk_det),
    .overrun    (overrun),
    .wake_en    (wake_en),
    .wake_evt   (wake_evt)
);

// File: tb/tb_uart_rx_wake.sv
module tb_uart_rx_wake;
    localparam int TDIV    = 4;
    localparam int BIT_CLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rxd = 1'b1;
    logic       wake_set = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, brk_det, overrun, wake_en, wake_evt;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int tdiv = 0;
    int wake_cnt = 0;
    int rise_cyc = 0;
    int last_t0 = 0;
    bit started = 0;
    bit mon_en = 0;
    bit auto_rd = 1;
    bit done = 0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    end
    assign os_tick = (tdiv == 0);

    uart_rx_wake dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .wake_set(wake_set), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_valid(rx_valid), .frame_err(frame_err), .brk_det(brk_det),
        .overrun(overrun), .wake_en(wake_en), .wake_evt(wake_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // monitor: compares each newly valid byte against the scoreboard
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (wake_evt) wake_cnt++;
            if (rd_ack && auto_rd) rd_ack = 1'b0;
            if (mon_en && rx_valid && !prev) begin
                rise_cyc = cyc;
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected byte", rx_data, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk({brk_det, frame_err, rx_data} == e, "R2/R4/R5 byte+flags",
                        {brk_det, frame_err, rx_data}, e);
                end
                if (auto_rd) rd_ack = 1'b1;
            end
            prev = rx_valid;
        end
    end

    task automatic align();
        @(negedge clk);
        while (tdiv != 0) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // driver: sends a frame and pushes what is expected
    task automatic send_byte(input logic [7:0] d, input logic stopb, input bit expect_it);
        if (expect_it) exp_q.push_back({(!stopb && d == 8'h00), !stopb, d});
        align();
        last_t0 = cyc;
        started = 1;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(stopb);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_low(input int nbits, input bit expect_brk);
        if (expect_brk) exp_q.push_back({1'b1, 1'b1, 8'h00});
        align();
        rxd = 1'b0;
        repeat (nbits * BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    initial begin : main
        int lat;
        fork
            begin
                repeat (150000) @(posedge clk);
                chk(0, "watchdog", cyc, 0);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rx_valid == 0 && frame_err == 0 && brk_det == 0, "R1 flags", {rx_valid, frame_err, brk_det}, 0);
        chk(overrun == 0 && wake_en == 0 && wake_evt == 0, "R1 wake/ovr", {overrun, wake_en, wake_evt}, 0);
        chk(rx_data == 8'h00, "R1 data", rx_data, 0);
        mon_en = 1;

        // R2 normal frames, latency measured on the first
        send_byte(8'hA5, 1'b1, 1);
        lat = rise_cyc - last_t0;
        chk(rx_valid == 0 && frame_err == 0, "R7 read clears", {rx_valid, frame_err}, 0);
        send_byte(8'h00, 1'b1, 1);
        send_byte(8'hFF, 1'b1, 1);
        send_byte(8'h3C, 1'b1, 1);

        // R3 short glitch on the line
        align();
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        chk(rx_valid == 0, "R3 glitch rejected", rx_valid, 0);
        send_byte(8'h81, 1'b1, 1);

        // R4 framing error with non-zero data
        send_byte(8'h5A, 1'b0, 1);
        chk(frame_err == 0 && brk_det == 0, "R7 ferr cleared by read", {frame_err, brk_det}, 0);

        // R5 and R6: long break yields one byte
        send_low(24, 1);
        chk(exp_q.size() == 0, "R6 single byte from long low", exp_q.size(), 0);
        chk(rx_valid == 0, "R6 no extra byte", rx_valid, 0);
        send_byte(8'h6E, 1'b1, 1);

        // R8 overrun
        auto_rd = 0;
        send_byte(8'h11, 1'b1, 1);
        send_byte(8'h22, 1'b1, 0);
        chk(overrun == 1, "R8 overrun set", overrun, 1);
        chk(rx_data == 8'h11 && rx_valid == 1, "R8 held byte kept", rx_data, 8'h11);
        do_read();
        @(negedge clk);
        chk(overrun == 0 && rx_valid == 0, "R8/R7 cleared by read", {overrun, rx_valid}, 0);

        // R9 read on the completion edge
        send_byte(8'h33, 1'b1, 1);
        started = 0;
        fork
            send_byte(8'h44, 1'b1, 0);
            begin
                wait (started);
                while (cyc != last_t0 + lat - 1) @(negedge clk);
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        join
        chk(rx_valid == 1 && rx_data == 8'h44, "R9 new byte loaded", rx_data, 8'h44);
        chk(overrun == 0, "R9 no overrun", overrun, 0);
        do_read();
        @(negedge clk);
        auto_rd = 1;

        // R10..R12 wake mode
        @(negedge clk); wake_set = 1'b1;
        @(negedge clk); wake_set = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        chk(wake_en == 1, "R10 armed", wake_en, 1);
        chk(wake_cnt == 0, "R11 no event on idle line", wake_cnt, 0);
        send_low(13, 0);
        chk(rx_valid == 0, "R10 no frame while armed", rx_valid, 0);
        chk(wake_cnt == 1, "R11 one wake pulse", wake_cnt, 1);
        chk(wake_en == 0, "R11 self-clear", wake_en, 0);
        send_byte(8'h55, 1'b1, 1);
        chk(exp_q.size() == 0, "R12 byte after wake seen", exp_q.size(), 0);

        repeat (BIT_CLK) @(negedge clk);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule